// File: doc/BRIEF.md
# Delta-Coded Sample Level Generator

This block turns a stream of packed one-bit delta samples into a 7-bit audio level. A programmable rate timer, whose period is chosen by a 4-bit rate index from a 16-entry period table, fires a one-clock step strobe. On every step the block consumes one bit of the byte it is playing, least significant bit first. A 1 raises the level by 2 and a 0 lowers it by 2. The level clamps at both ends instead of wrapping.

Bytes arrive from an upstream one-byte reader buffer over a valid/ready stream. The source raises `smp_valid` while it holds a byte and must keep `smp_data` steady until the byte is taken. The block raises `smp_ready` only in the step cycle that closes a byte, so it holds the source back for up to eight step periods. If no byte is offered at that moment, the next eight steps are silent: the bits are still counted, but the level does not move. A direct level write sets the level without waiting for the timer. `step_strobe` is exported so that observers can sample the level at step boundaries.

Top module: `dpcm_level_unit`

## Requirements
- R1: `step_strobe` is high for exactly one clock, once every P clocks, where P is the period table entry selected by the current rate index. The default entries from index 0 to 15 are 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54, and every entry must be at least 2.
- R2: A rate write (`rate_we` with `rate_idx`) does not restart the running countdown. The new period takes effect from the next reload. The interval that is running when the write is made keeps the old length.
- R3: After reset the period is table entry 0, and the timer does not fire on the first clock. `step_strobe` first goes high in the cycle that follows the 427th rising edge after reset release.
- R4: On a step while playing, bit 0 of the shift register is consumed and the register shifts right. A 1 adds 2 to the level if the level is 125 or less, and otherwise leaves the level unchanged.
- R5: On a step while playing, a 0 bit subtracts 2 from the level if the level is 2 or more, and otherwise leaves the level unchanged.
- R6: Every step decrements the bits-left count, silent or not. The step that brings the count from 1 to 0 closes a byte and reloads the count to 8. `smp_ready` is high only in that cycle, and only while `smp_valid` is high.
- R7: When a byte closes and a byte is offered, that byte is loaded and playing resumes. When no byte is offered, the block goes silent and the level stays fixed for the next 8 steps.
- R8: A write with `lvl_we` sets the level to bits 6:0 of `lvl_val`, and bit 7 is ignored. The new level shows on `level_out` after the next rising edge, whatever the timer is doing. A write in a step cycle takes priority over that step.
- R9: After reset `level_out` is 0, the block is silent with 8 bits left, and `smp_ready` is low.
- R10: A byte is transferred only on a rising edge where both `smp_valid` and `smp_ready` are high. A source may hold `smp_valid` high for any number of cycles without losing or duplicating its byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_we | input | 1 | Rate index write strobe |
| rate_idx | input | 4 | Rate index into the period table |
| lvl_we | input | 1 | Direct level write strobe |
| lvl_val | input | 8 | Direct level value (bits 6:0 used) |
| smp_valid | input | 1 | Sample byte offered by the reader buffer |
| smp_data | input | 8 | Sample byte, bit 0 played first |
| smp_ready | output | 1 | Byte taken this cycle |
| level_out | output | 7 | Current output level |
| step_strobe | output | 1 | One-clock timer expiry strobe |

## Verification
A wrong timer count shifts every later step edge, so `step_strobe` shows a period error within one period and the level starts to drift from that point. A corrupted bit count or silence flag shows up at the next byte boundary, at most eight steps later: `smp_ready` comes in the wrong cycle, or the level moves during a gap when it should hold. A wrong shift register value, or a clamp error, shows up in `level_out` on the very step that consumes the bad bit. The bench checks `level_out` against its reference on every clock, so the first bad step is caught in the cycle where it happens.

// File: rtl/dpcm_pkg.sv
package dpcm_pkg;
  localparam int RATES = 16;
  localparam int unsigned DEF_PERIODS [RATES] = '{
    428, 380, 340, 320, 286, 254, 226, 214,
    190, 160, 142, 128, 106,  84,  72,  54
  };

  typedef enum logic {PLAY = 1'b0, MUTE = 1'b1} play_e;
endpackage

// File: rtl/dpcm_rate_timer.sv
module dpcm_rate_timer #(
  parameter int IDX_W = 4,
  parameter int TMR_W = 9,
  parameter int unsigned PERIODS [2**IDX_W] = dpcm_pkg::DEF_PERIODS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_we,
  input  logic [IDX_W-1:0] rate_idx,
  output logic             expire
);
  localparam logic [TMR_W-1:0] RST_RELOAD = TMR_W'(PERIODS[0] - 1);

  logic [TMR_W-1:0] reload_q;
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] reload_new;

  assign reload_new = TMR_W'(PERIODS[rate_idx] - 1);
  assign expire     = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RST_RELOAD;
      cnt_q    <= RST_RELOAD;
    end else begin
      if (expire) cnt_q <= reload_q;
      else        cnt_q <= cnt_q - 1'b1;
      if (rate_we) reload_q <= reload_new;
    end
  end
endmodule

// File: rtl/dpcm_bit_shifter.sv
module dpcm_bit_shifter
  import dpcm_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              smp_ready,
  output logic              cur_bit,
  output logic              silent
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  bits_q;
  play_e             mode_q;
  logic              boundary;

  assign boundary  = expire && (bits_q == LAST);
  assign smp_ready = boundary && smp_valid;
  assign cur_bit   = sh_q[0];
  assign silent    = (mode_q == MUTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bits_q <= FULL;
      mode_q <= MUTE;
    end else if (expire) begin
      if (mode_q == PLAY) sh_q <= sh_q >> 1;
      if (boundary) begin
        bits_q <= FULL;
        if (smp_valid) begin
          sh_q   <= smp_data;
          mode_q <= PLAY;
        end else begin
          mode_q <= MUTE;
        end
      end else begin
        bits_q <= bits_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpcm_level_acc.sv
module dpcm_level_acc #(
  parameter int LEVEL_W = 7,
  parameter int STEP    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic               step_up,
  input  logic               load_en,
  input  logic [LEVEL_W-1:0] load_val,
  output logic [LEVEL_W-1:0] level
);
  localparam logic [LEVEL_W-1:0] LVL_MAX = {LEVEL_W{1'b1}};
  localparam logic [LEVEL_W-1:0] STEP_V  = LEVEL_W'(STEP);
  localparam logic [LEVEL_W-1:0] UP_LIM  = LVL_MAX - STEP_V;

  logic [LEVEL_W-1:0] lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (step_en) begin
      if (step_up) begin
        if (lvl_q <= UP_LIM) lvl_d = lvl_q + STEP_V;
      end else if (lvl_q >= STEP_V) begin
        lvl_d = lvl_q - STEP_V;
      end
    end
    if (load_en) lvl_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  assign level = lvl_q;
endmodule

// File: rtl/dpcm_level_unit.sv
module dpcm_level_unit #(
  parameter int DATA_W  = 8,
  parameter int LEVEL_W = 7,
  parameter int IDX_W   = 4,
  parameter int TMR_W   = 9,
  parameter int STEP    = 2,
  parameter int unsigned PERIOD_TAB [2**IDX_W] = dpcm_pkg::DEF_PERIODS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rate_we,
  input  logic [IDX_W-1:0]   rate_idx,
  input  logic               lvl_we,
  input  logic [DATA_W-1:0]  lvl_val,
  input  logic               smp_valid,
  input  logic [DATA_W-1:0]  smp_data,
  output logic               smp_ready,
  output logic [LEVEL_W-1:0] level_out,
  output logic               step_strobe
);
  logic expire;
  logic cur_bit;
  logic silent;

  dpcm_rate_timer #(
    .IDX_W(IDX_W), .TMR_W(TMR_W), .PERIODS(PERIOD_TAB)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .rate_we(rate_we), .rate_idx(rate_idx),
    .expire(expire)
  );

  dpcm_bit_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .expire(expire),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .cur_bit(cur_bit), .silent(silent)
  );

  dpcm_level_acc #(.LEVEL_W(LEVEL_W), .STEP(STEP)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .step_en(expire && !silent), .step_up(cur_bit),
    .load_en(lvl_we), .load_val(lvl_val[LEVEL_W-1:0]),
    .level(level_out)
  );

  assign step_strobe = expire;
endmodule

// File: rtl/dpcm_level_unit_chk.sv
module dpcm_level_unit_chk #(
  parameter int DATA_W  = 8,
  parameter int LEVEL_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lvl_we,
  input logic [DATA_W-1:0]  lvl_val,
  input logic               smp_valid,
  input logic               smp_ready,
  input logic [LEVEL_W-1:0] level_out,
  input logic               step_strobe,
  input logic               silent,
  input logic               cur_bit
);
  localparam logic [LEVEL_W-1:0] LVL_MAX = {LEVEL_W{1'b1}};
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  a_r1_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    step_strobe |=> !step_strobe);

  a_r3_no_first_fire: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !step_strobe);

  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    step_strobe && !silent && cur_bit && !lvl_we && (level_out <= LVL_MAX - 2)
    |=> level_out == $past(level_out) + 2);

  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    step_strobe && !silent && !cur_bit && !lvl_we && (level_out >= 2)
    |=> level_out == $past(level_out) - 2);

  a_r6_take_at_step: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> step_strobe && smp_valid);

  a_r7_mute_holds: assert property (@(posedge clk) disable iff (!rst_n)
    step_strobe && silent && !lvl_we |=> $stable(level_out));

  a_r8_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_we |=> level_out == $past(lvl_val[LEVEL_W-1:0]));

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_strobe && !lvl_we |=> $stable(level_out));
endmodule

bind dpcm_level_unit dpcm_level_unit_chk #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lvl_we(lvl_we), .lvl_val(lvl_val),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .level_out(level_out),
  .step_strobe(step_strobe), .silent(silent), .cur_bit(cur_bit)
);

// File: tb/dpcm_level_unit_bench.sv
module dpcm_level_unit_bench;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate_we = 1'b0;
  logic [3:0] rate_idx = '0;
  logic       lvl_we = 1'b0;
  logic [7:0] lvl_val = '0;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_data = '0;
  logic       smp_ready;
  logic [6:0] level_out;
  logic       step_strobe;

  dpcm_level_unit u_dpcm_level_unit (
    .clk(clk), .rst_n(rst_n), .rate_we(rate_we), .rate_idx(rate_idx),
    .lvl_we(lvl_we), .lvl_val(lvl_val), .smp_valid(smp_valid),
    .smp_data(smp_data), .smp_ready(smp_ready), .level_out(level_out),
    .step_strobe(step_strobe)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit take_n = 0;
  byte unsigned q[$];
  int tab [16] = '{428, 380, 340, 320, 286, 254, 226, 214,
                   190, 160, 142, 128, 106, 84, 72, 54};

  // behavioural reference
  int m_cnt, m_per, m_bits, m_lvl, m_sh;
  bit m_sil;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_per = tab[0] - 1; m_cnt = m_per; m_bits = 8;
      m_lvl = 0; m_sil = 1; m_sh = 0;
    end else begin
      bit fire;
      fire = (m_cnt == 0);
      m_cnt = fire ? m_per : m_cnt - 1;
      if (fire) begin
        if (!m_sil) begin
          if (m_sh % 2 == 1) begin if (m_lvl <= 125) m_lvl += 2; end
          else if (m_lvl >= 2) m_lvl -= 2;
          m_sh = m_sh / 2;
        end
        m_bits--;
        if (m_bits == 0) begin
          m_bits = 8;
          if (smp_valid) begin m_sh = smp_data; m_sil = 0; end
          else m_sil = 1;
        end
      end
      if (lvl_we) m_lvl = lvl_val % 128;
      if (rate_we) m_per = tab[rate_idx] - 1;
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(level_out, m_lvl, "R4 R5 R7 R8 level");
      chk(step_strobe, (m_cnt == 0), "R1 R2 R3 strobe");
      chk(smp_ready, (m_cnt == 0) && (m_bits == 1) && smp_valid, "R6 R10 ready");
      take_n = smp_valid && smp_ready;
    end
  end

  // source model of the reader buffer
  always @(posedge clk) begin
    #1;
    if (take_n) begin void'(q.pop_front()); take_n = 0; end
    smp_valid = (q.size() > 0);
    smp_data  = (q.size() > 0) ? q[0] : 8'h00;
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wait_step(output int n);
    n = 0;
    do begin tick(); n++; end while (!step_strobe);
  endtask

  task automatic load(input logic [7:0] v);
    lvl_we = 1; lvl_val = v; tick(); lvl_we = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    chk(level_out, 0, "R9 reset level");
    chk(smp_ready, 0, "R9 reset ready");
    wait_step(n);
    chk(n, 426, "R3 first strobe edge count");
    rate_idx = 4'd15; rate_we = 1; tick(); rate_we = 0;
    wait_step(n);
    chk(n + 1, 428, "R2 running interval keeps old period");
    wait_step(n);
    chk(n, 54, "R1 new period 54");
    q.push_back(8'hFF); q.push_back(8'hFF);
    repeat (30 * 54) tick();
    load(8'd120);
    chk(level_out, 120, "R8 direct load");
    q.push_back(8'hFF); q.push_back(8'hFF); q.push_back(8'hFF);
    repeat (34 * 54) tick();
    chk(level_out, 126, "R4 upper clamp");
    load(8'h83);
    chk(level_out, 3, "R8 bit 7 ignored");
    q.push_back(8'h00); q.push_back(8'h00);
    repeat (26 * 54) tick();
    chk(level_out, 1, "R5 lower clamp");
    q.push_back(8'hA5); q.push_back(8'h5A); q.push_back(8'h33);
    repeat (10 * 54) tick();
    rate_idx = 4'd13; rate_we = 1; tick(); rate_we = 0;
    repeat (30 * 84) tick();
    n = level_out;
    repeat (8 * 84) tick();
    chk(level_out, n, "R7 silent gap holds level");
    wait_step(n);
    load(8'hFF);
    chk(level_out, 127, "R8 load wins over step");
    q.push_back(8'h01); q.push_back(8'h00);
    repeat (26 * 84) tick();
    chk(q.size(), 0, "R10 all bytes taken once");
    done = 1;
    summary();
    $finish;
  end
endmodule